// File: doc/BRIEF.md
# Nested Prioritized Event Controller

The block arbitrates the sixteen event levels of a processor core. It latches event requests, filters them through a mask, and decides each cycle whether the highest-priority latched request may preempt the code that is running. On an entry it produces a one-cycle strobe with the accepted level, selects the return-address register to load, computes the value for it, and flags when the vector should come from the reset slot. A software register window gives access to the vector-override, mask, pending, latch and priority registers.

Level 0 is emulation, 1 is reset, 2 is the non-maskable interrupt, 3 is the exception, 4 is a global-disable flag held in the pending register, 5 is hardware error, 6 is timer, and 7 to 15 are general interrupts. A lower index means a higher priority. The core's current level is the lowest-index pending bit, ignoring bits 0 and 4. The block re-evaluates the latch against the mask in every cycle, so a request that is unmasked, released or uncovered by a return is taken on the next cycle without any further stimulus. Return-address sequencing, vector contents and next-PC computation stay outside the block; `ret_i` and `reen_i` are the pulses through which the core reports a return and a release of the global disable.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After synchronous reset the mask reads 0x0000001F, pending reads 0x00000012, latch reads 0, `cur_lvl_o` is 1 and `super_o` is 1.
- R2: The register window decodes byte offsets 0x00 override, 0x04 mask, 0x08 pending, 0x0C latch and 0x10 priority. The 16-bit registers read with bits 31:16 zero, and other offsets read 0. A mask write keeps bits 4:0 at 1. Pending ignores writes. A priority write keeps only bits 4:0.
- R3: A `req_i` bit sets its latch bit at the next edge. A write of 1 to a latch bit clears it. A request and a clearing write to the same bit in the same cycle leave the bit set.
- R4: `cur_lvl_o` is the lowest set pending bit, excluding bits 0 and 4, or 16 when none remains. `super_o` is 1 when a pending bit other than 0 or 4 is set.
- R5: A latched, unmasked request at level 5 or above is taken when pending bit 4 is clear or the core is at level 16, and its level is lower than `cur_lvl_o`. Entry is taken one edge after the latch edge: `take_o` pulses, the pending bit is set, the latch bit is cleared, and bit 4 is set.
- R6: A masked request stays latched. A mask write that unmasks it leads to the entry on the following edge.
- R7: A request at the current level is taken only while `snen_i` is 1. The return value is then `pc_i` with bit 0 forced to 1.
- R8: Emulation and reset requests are always taken. `ret_sel_o` codes are 0 emulation, 1 NMI, 2 exception and 3 for every other level, and the return value for these is `pc_i`.
- R9: An NMI or exception request while `cur_lvl_o` is less than or equal to its level pulses `dfault_o` with `fault_cause_o` = 0x21, drops the latch bit and makes no entry.
- R10: An entry at level 7 to 15 whose override bit (override register bit = level) is set drives `vec_reset_o` = 1. In every other case `vec_reset_o` is 0.
- R11: On an exception entry the return value is `pc_i` when `cause_i` >= 0x20, and `next_pc_i` otherwise.
- R12: `ret_i` clears the emulation bit if it is set, and otherwise clears the current level's bit plus bit 4 when that level is 1 or 5 and above. No entry is taken in a `ret_i` cycle. `reen_i` clears bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Event request pulses, one per level |
| snen_i | input | 1 | Self-nesting enable |
| reen_i | input | 1 | Release of the global disable bit |
| ret_i | input | 1 | Return from the running level |
| pc_i | input | 32 | PC of the instruction to be executed |
| next_pc_i | input | 32 | PC following the current instruction |
| cause_i | input | 6 | Exception cause |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| take_o | output | 1 | Entry strobe |
| take_lvl_o | output | 4 | Level of the last entry or double fault |
| vec_reset_o | output | 1 | Use the reset vector for this entry |
| ret_sel_o | output | 2 | Return-address register select |
| ret_val_o | output | 32 | Value for the selected return register |
| dfault_o | output | 1 | Double-fault strobe |
| fault_cause_o | output | 6 | Cause reported with a double fault |
| cur_lvl_o | output | 5 | Current level, 16 means user |
| super_o | output | 1 | Supervisor mode |

## Verification
Two pairs of functions can collide on the latch in the same cycle. The first pair is the write-one-to-clear path and a fresh request. The bench raises a request on the same bit, in the same cycle, as a clearing write, and expects the bit to survive. The second pair is a return and the pending-check pass. The bench latches a request while the global disable blocks it, then issues the return. A scoreboard then expects the entry on the edge after the return and not in the return cycle.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int NLVL     = 16;
    localparam int LW       = $clog2(NLVL);
    localparam int UNMASK_N = 5;

    localparam int L_EMU  = 0;
    localparam int L_RST  = 1;
    localparam int L_NMI  = 2;
    localparam int L_EXC  = 3;
    localparam int L_GDIS = 4;
    localparam int L_HWE  = 5;
    localparam int L_OVR  = 7;

    localparam logic [LW:0] USER_LVL = (LW+1)'(NLVL);

    typedef enum logic [1:0] {
        RS_EMU = 2'd0,
        RS_NMI = 2'd1,
        RS_EXC = 2'd2,
        RS_INT = 2'd3
    } ret_sel_e;

    typedef enum logic [2:0] {
        WA_OVR  = 3'd0,
        WA_MASK = 3'd1,
        WA_PEND = 3'd2,
        WA_LAT  = 3'd3,
        WA_PRIO = 3'd4
    } word_e;

    typedef struct packed {
        logic          take;
        logic          dfault;
        logic          nest;
        logic [LW-1:0] lvl;
    } verdict_t;

    function automatic logic [LW:0] lowest_set(input logic [NLVL-1:0] v);
        logic [LW:0] r;
        r = USER_LVL;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (v[i]) r = (LW+1)'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/evc_regs.sv
module evc_regs import evc_pkg::*; #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NLVL-1:0]   pend_i,
    input  logic [NLVL-1:0]   lat_i,
    output logic [NLVL-1:0]   mask_o,
    output logic [NLVL-1:0]   ovr_o,
    output logic [NLVL-1:0]   w1c_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int IW = ADDR_W - 2;
    localparam logic [NLVL-1:0] UNMASK_BITS = NLVL'((1 << UNMASK_N) - 1);

    logic [IW-1:0]       widx;
    logic [NLVL-1:0]     mask_q, ovr_q;
    logic [UNMASK_N-1:0] prio_q;

    assign widx = addr_i[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= UNMASK_BITS;
            ovr_q  <= '0;
            prio_q <= '0;
        end else if (we_i) begin
            if (widx == IW'(WA_MASK)) mask_q <= wdata_i[NLVL-1:0] | UNMASK_BITS;
            if (widx == IW'(WA_OVR))  ovr_q  <= wdata_i[NLVL-1:0];
            if (widx == IW'(WA_PRIO)) prio_q <= wdata_i[UNMASK_N-1:0];
        end
    end

    assign w1c_o  = (we_i && widx == IW'(WA_LAT)) ? wdata_i[NLVL-1:0] : '0;
    assign mask_o = mask_q;
    assign ovr_o  = ovr_q;

    always_comb begin
        rdata_o = '0;
        case (widx)
            IW'(WA_OVR):  rdata_o = DATA_W'(ovr_q);
            IW'(WA_MASK): rdata_o = DATA_W'(mask_q);
            IW'(WA_PEND): rdata_o = DATA_W'(pend_i);
            IW'(WA_LAT):  rdata_o = DATA_W'(lat_i);
            IW'(WA_PRIO): rdata_o = DATA_W'(prio_q);
            default:      rdata_o = '0;
        endcase
    end

    AST_MASK_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (we_i && widx == IW'(WA_MASK)) |=>
            mask_q[NLVL-1:UNMASK_N] == $past(wdata_i[NLVL-1:UNMASK_N])); // R2

endmodule

// File: rtl/evc_arbiter.sv
module evc_arbiter import evc_pkg::*; (
    input  logic [NLVL-1:0] lat_i,
    input  logic [NLVL-1:0] mask_i,
    input  logic [LW:0]     cur_i,
    input  logic            gdis_i,
    input  logic            snen_i,
    output verdict_t        vd_o
);
    logic [NLVL-1:0] cand;
    logic [LW:0]     c;

    always_comb begin
        cand         = lat_i & mask_i;
        cand[L_GDIS] = 1'b0;
        c            = lowest_set(cand);
        vd_o         = '0;
        vd_o.lvl     = c[LW-1:0];
        if (c != USER_LVL) begin
            if (c <= (LW+1)'(L_RST)) begin
                vd_o.take = 1'b1;
            end else if (c <= (LW+1)'(L_EXC)) begin
                if (cur_i <= c) vd_o.dfault = 1'b1;
                else            vd_o.take   = 1'b1;
            end else if ((!gdis_i || cur_i == USER_LVL) &&
                         (c < cur_i || (snen_i && c == cur_i))) begin
                vd_o.take = 1'b1;
                vd_o.nest = (c == cur_i);
            end
        end
    end

endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl import evc_pkg::*; #(
    parameter int PC_W        = 32,
    parameter int CAUSE_W     = 6,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int UNCOV_CAUSE = 'h21,
    parameter int SVC_LIMIT   = 'h20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NLVL-1:0]    req_i,
    input  logic               snen_i,
    input  logic               reen_i,
    input  logic               ret_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [PC_W-1:0]    next_pc_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               take_o,
    output logic [LW-1:0]      take_lvl_o,
    output logic               vec_reset_o,
    output logic [1:0]         ret_sel_o,
    output logic [PC_W-1:0]    ret_val_o,
    output logic               dfault_o,
    output logic [CAUSE_W-1:0] fault_cause_o,
    output logic [LW:0]        cur_lvl_o,
    output logic               super_o
);
    localparam logic [NLVL-1:0] RST_PEND = NLVL'((1 << L_RST) | (1 << L_GDIS));
    localparam logic [NLVL-1:0] LVL_IGN  = NLVL'((1 << L_EMU) | (1 << L_GDIS));

    logic [NLVL-1:0] pend_q, pend_n, lat_q, lat_n, lat_clr;
    logic [NLVL-1:0] mask, ovr, w1c;
    logic [LW:0]     cur;
    logic            go, fault;
    verdict_t        vd;
    ret_sel_e        sel;
    logic [PC_W-1:0] rval;

    evc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .pend_i(pend_q), .lat_i(lat_q),
        .mask_o(mask), .ovr_o(ovr), .w1c_o(w1c), .rdata_o(reg_rdata_o)
    );

    assign cur = lowest_set(pend_q & ~LVL_IGN);

    evc_arbiter u_arb (
        .lat_i(lat_q), .mask_i(mask), .cur_i(cur),
        .gdis_i(pend_q[L_GDIS]), .snen_i(snen_i), .vd_o(vd)
    );

    assign go      = vd.take   && !ret_i;
    assign fault   = vd.dfault && !ret_i;
    assign lat_clr = (go || fault) ? (NLVL'(1) << vd.lvl) : '0;
    assign lat_n   = (lat_q & ~w1c & ~lat_clr) | req_i;

    always_comb begin
        pend_n = pend_q;
        if (reen_i) pend_n[L_GDIS] = 1'b0;
        if (ret_i) begin
            if (pend_q[L_EMU]) begin
                pend_n[L_EMU] = 1'b0;
            end else if (cur != USER_LVL) begin
                pend_n[cur[LW-1:0]] = 1'b0;
                if (cur >= (LW+1)'(L_HWE) || cur == (LW+1)'(L_RST)) pend_n[L_GDIS] = 1'b0;
            end
        end else if (go) begin
            pend_n[vd.lvl] = 1'b1;
            if (vd.lvl >= LW'(L_HWE)) pend_n[L_GDIS] = 1'b1;
        end
    end

    always_comb begin
        case (vd.lvl)
            LW'(L_EMU): begin sel = RS_EMU; rval = pc_i; end
            LW'(L_NMI): begin sel = RS_NMI; rval = pc_i; end
            LW'(L_EXC): begin
                sel  = RS_EXC;
                rval = (cause_i >= CAUSE_W'(SVC_LIMIT)) ? pc_i : next_pc_i;
            end
            default: begin sel = RS_INT; rval = pc_i | PC_W'(vd.nest); end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q        <= RST_PEND;
            lat_q         <= '0;
            take_o        <= 1'b0;
            take_lvl_o    <= '0;
            vec_reset_o   <= 1'b0;
            ret_sel_o     <= RS_INT;
            ret_val_o     <= '0;
            dfault_o      <= 1'b0;
            fault_cause_o <= '0;
        end else begin
            pend_q        <= pend_n;
            lat_q         <= lat_n;
            take_o        <= go;
            dfault_o      <= fault;
            fault_cause_o <= fault ? CAUSE_W'(UNCOV_CAUSE) : '0;
            vec_reset_o   <= go && vd.lvl >= LW'(L_OVR) && ovr[vd.lvl];
            if (go || fault) take_lvl_o <= vd.lvl;
            if (go) begin
                ret_sel_o <= sel;
                ret_val_o <= rval;
            end
        end
    end

    assign cur_lvl_o = cur;
    assign super_o   = |(pend_q & ~LVL_IGN);

    AST_TAKE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(take_o && dfault_o)); // R9

    AST_ENTRY_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        take_o |-> pend_q[take_lvl_o]); // R5

    AST_ENTRY_SETS_GDIS: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_lvl_o >= LW'(L_HWE)) |-> pend_q[L_GDIS]); // R5

    AST_DFAULT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        dfault_o |-> ($past(cur) <= {1'b0, take_lvl_o})); // R9

    AST_PEND_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(WA_PEND) &&
         !ret_i && !reen_i && !go) |=> $stable(pend_q)); // R2

    AST_NO_TAKE_ON_RET: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> !take_o); // R12

endmodule

// File: tb/test_evt_nest_ctrl.sv
module test_evt_nest_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req = '0;
    logic        snen = 1'b0, reen = 1'b0, ret = 1'b0;
    logic [31:0] pc = 32'h0000_1234, npc = 32'h0000_1238;
    logic [5:0]  cause = 6'h00;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        take_o, vec_reset_o, dfault_o, super_o;
    logic [3:0]  take_lvl_o;
    logic [1:0]  ret_sel_o;
    logic [31:0] ret_val_o;
    logic [5:0]  fault_cause_o;
    logic [4:0]  cur_lvl_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          flt;
        int          lvl;
        int          sel;
        logic [31:0] val;
        bit          vr;
        string       rq;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    evt_nest_ctrl i_evt_nest_ctrl (
        .clk(clk), .rst(rst), .req_i(req), .snen_i(snen), .reen_i(reen),
        .ret_i(ret), .pc_i(pc), .next_pc_i(npc), .cause_i(cause),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .take_o(take_o), .take_lvl_o(take_lvl_o),
        .vec_reset_o(vec_reset_o), .ret_sel_o(ret_sel_o), .ret_val_o(ret_val_o),
        .dfault_o(dfault_o), .fault_cause_o(fault_cause_o),
        .cur_lvl_o(cur_lvl_o), .super_o(super_o)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string rq);
        @(negedge clk); addr = a; #1;
        chk(rdata == exp, rq, "register read", rdata, exp);
    endtask

    task automatic pulse_req(input int b);
        @(negedge clk); req = 16'(1) << b;
        @(negedge clk); req = '0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0;
    endtask

    task automatic pulse_reen();
        @(negedge clk); reen = 1'b1;
        @(negedge clk); reen = 1'b0;
    endtask

    task automatic expect_take(input int l, input int s, input logic [31:0] v,
                               input bit vr, input string rq);
        exp_t e;
        e.flt = 1'b0; e.lvl = l; e.sel = s; e.val = v; e.vr = vr; e.rq = rq;
        sb.push_back(e);
    endtask

    task automatic expect_fault(input int l, input string rq);
        exp_t e;
        e.flt = 1'b1; e.lvl = l; e.sel = 0; e.val = '0; e.vr = 1'b0; e.rq = rq;
        sb.push_back(e);
    endtask

    // monitor: pops the scoreboard whenever an entry or double fault appears
    always @(negedge clk) begin
        if (!rst && (take_o || dfault_o)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R5", "unexpected event at level", 32'(take_lvl_o), 32'hffff_ffff);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(32'(take_lvl_o) == e.lvl, e.rq, "event level", 32'(take_lvl_o), e.lvl);
                if (e.flt) begin
                    chk(dfault_o && !take_o, e.rq, "double-fault strobe", {30'd0, dfault_o, take_o}, 32'h2);
                    chk(fault_cause_o == 6'h21, e.rq, "fault cause", 32'(fault_cause_o), 32'h21);
                end else begin
                    chk(take_o && !dfault_o, e.rq, "entry strobe", {30'd0, take_o, dfault_o}, 32'h2);
                    chk(32'(ret_sel_o) == e.sel, e.rq, "return select", 32'(ret_sel_o), e.sel);
                    chk(ret_val_o == e.val, e.rq, "return value", ret_val_o, e.val);
                    chk(vec_reset_o == e.vr, e.rq, "reset-vector flag", 32'(vec_reset_o), 32'(e.vr));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        rd(5'h04, 32'h0000_001f, "R1");
        rd(5'h08, 32'h0000_0012, "R1");
        rd(5'h0c, 32'h0, "R1");
        chk(cur_lvl_o == 5'd1, "R1", "current level", 32'(cur_lvl_o), 1);
        chk(super_o == 1'b1, "R1", "supervisor", 32'(super_o), 1);

        // R12 return from reset level, R4 user level
        pulse_ret();
        rd(5'h08, 32'h0, "R12");
        chk(cur_lvl_o == 5'd16, "R4", "user level", 32'(cur_lvl_o), 16);
        chk(super_o == 1'b0, "R4", "user mode", 32'(super_o), 0);

        // R2 register window
        wr(5'h04, 32'h0);
        rd(5'h04, 32'h0000_001f, "R2");
        wr(5'h04, 32'hffff_ffff);
        rd(5'h04, 32'h0000_ffff, "R2");
        wr(5'h08, 32'h0000_ffff);
        rd(5'h08, 32'h0, "R2");
        wr(5'h10, 32'h0000_abcd);
        rd(5'h10, 32'h0000_000d, "R2");
        wr(5'h00, 32'h1234_5678);
        rd(5'h00, 32'h0000_5678, "R2");
        rd(5'h14, 32'h0, "R2");
        wr(5'h00, 32'h0);

        // R5 entry from user level
        expect_take(9, 3, 32'h1234, 1'b0, "R5");
        pulse_req(9);
        idle(2);
        rd(5'h08, 32'h0000_0210, "R5");
        rd(5'h0c, 32'h0, "R5");
        chk(cur_lvl_o == 5'd9, "R4", "current level", 32'(cur_lvl_o), 9);

        // R5 global disable blocks; R12 return then pending check takes it
        pulse_req(7);
        idle(3);
        rd(5'h0c, 32'h0000_0080, "R5");
        expect_take(7, 3, 32'h1234, 1'b0, "R12");
        pulse_ret();
        idle(2);
        rd(5'h08, 32'h0000_0090, "R12");

        // R7 self-nesting
        pulse_reen();
        rd(5'h08, 32'h0000_0080, "R12");
        pulse_req(7);
        idle(3);
        rd(5'h0c, 32'h0000_0080, "R7");
        expect_take(7, 3, 32'h1235, 1'b0, "R7");
        @(negedge clk); snen = 1'b1;
        idle(3);
        snen = 1'b0;
        rd(5'h0c, 32'h0, "R7");
        rd(5'h08, 32'h0000_0090, "R7");

        // R6 mask holds a request, unmasking releases it
        wr(5'h04, 32'h0000_ffbf);
        pulse_reen();
        pulse_req(6);
        idle(3);
        rd(5'h0c, 32'h0000_0040, "R6");
        expect_take(6, 3, 32'h1234, 1'b0, "R6");
        wr(5'h04, 32'h0000_ffff);
        idle(2);
        rd(5'h08, 32'h0000_00d0, "R6");
        chk(cur_lvl_o == 5'd6, "R4", "current level", 32'(cur_lvl_o), 6);

        pulse_ret();
        rd(5'h08, 32'h0000_0080, "R12");
        pulse_ret();
        rd(5'h08, 32'h0, "R12");

        // R10 vector override
        wr(5'h00, 32'h0000_1000);
        expect_take(12, 3, 32'h1234, 1'b1, "R10");
        pulse_req(12);
        idle(3);
        rd(5'h08, 32'h0000_1010, "R10");

        // R3 latch clear and same-cycle conflict
        pulse_req(10);
        idle(2);
        rd(5'h0c, 32'h0000_0400, "R3");
        wr(5'h0c, 32'h0000_0400);
        rd(5'h0c, 32'h0, "R3");
        @(negedge clk); we = 1'b1; addr = 5'h0c; wdata = 32'h0000_0800; req = 16'h0800;
        @(negedge clk); we = 1'b0; req = '0;
        rd(5'h0c, 32'h0000_0800, "R3");
        wr(5'h0c, 32'h0000_0800);
        rd(5'h0c, 32'h0, "R3");

        // R8 NMI entry, R9 exception inside NMI
        expect_take(2, 1, 32'h1234, 1'b0, "R8");
        pulse_req(2);
        idle(3);
        chk(cur_lvl_o == 5'd2, "R4", "current level", 32'(cur_lvl_o), 2);
        expect_fault(3, "R9");
        pulse_req(3);
        idle(3);
        rd(5'h0c, 32'h0, "R9");
        pulse_ret();
        rd(5'h08, 32'h0000_1010, "R12");

        // R11 exception return values
        cause = 6'h25;
        expect_take(3, 2, 32'h1234, 1'b0, "R11");
        pulse_req(3);
        idle(3);
        pulse_ret();
        cause = 6'h05;
        expect_take(3, 2, 32'h1238, 1'b0, "R11");
        pulse_req(3);
        idle(3);
        expect_fault(3, "R9");
        pulse_req(3);
        idle(3);
        pulse_ret();
        rd(5'h08, 32'h0000_1010, "R12");

        // R8 emulation always taken; emulation bit not part of level
        expect_take(0, 0, 32'h1234, 1'b0, "R8");
        pulse_req(0);
        idle(3);
        rd(5'h08, 32'h0000_1011, "R8");
        chk(cur_lvl_o == 5'd12, "R4", "level ignores emulation", 32'(cur_lvl_o), 12);
        pulse_ret();
        rd(5'h08, 32'h0000_1010, "R12");

        // R8 reset request taken despite global disable
        expect_take(1, 3, 32'h1234, 1'b0, "R8");
        pulse_req(1);
        idle(3);
        chk(cur_lvl_o == 5'd1, "R8", "current level", 32'(cur_lvl_o), 1);

        idle(2);
        chk(sb.size() == 0, "R5", "missing events", 32'(sb.size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule